// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a first-in first-out buffer between two clock domains. A writer pushes words on its own clock and a reader takes them on a second clock. The two clocks may be unrelated or may be the same net. The default shape is 4096 words of 18 bits.

A mode input is sampled while reset is held and picks one of two read timings. In standard timing the output word changes only on a read. In fall-through timing the oldest stored word is presented on the output on its own, and a read consumes it. The two fixed status flags change meaning with the mode.

Half-full, almost-empty and almost-full flags report fill level. The two almost thresholds start at a default value and can be reloaded through a small load sequencer on the write port. An output enable masks the read data bus and reports which bits are driven.

Top module: `dual_clock_fifo`

## Requirements
- R1: The buffer stores up to 2^ADDR_W words of DATA_W bits and returns them in the order they were written.
- R2: Standard timing (mode input 0 at reset): a stored word reaches `rd_data` only on a read clock edge with `rd_en` high. `rd_flag` = 1 means empty, and it clears on the second read clock edge after the write edge.
- R3: Fall-through timing (mode input 1 at reset): the first word written into an empty buffer appears on `rd_data` after the third read clock edge following its write edge, with no `rd_en`. `rd_flag` = 1 means a valid word is on `rd_data`, and it is held until a read edge consumes it.
- R4: `wr_flag` in standard timing is 1 when the write side counts 2^ADDR_W stored words (full). In fall-through timing it is 1 while the buffer is not full (input ready).
- R5: A write while full is ignored: no word is stored and the write pointer does not move.
- R6: A standard-timing read while empty is ignored: `rd_data` keeps its value and the read pointer does not move.
- R7: `half_full` is 1 when the write-side count is greater than 2^ADDR_W / 2.
- R8: `almost_empty` is 1 when the read-side count is at most the empty threshold. In fall-through timing that count includes the word on the output.
- R9: `almost_full` is 1 when the free space seen by the write side is at most the full threshold.
- R10: While `ld` is high, each write clock edge with `wr_en` high loads `wr_data[ADDR_W-1:0]` as a threshold and stores no data. The first such edge loads the empty threshold and the next loads the full threshold, then the sequence repeats. When `ld` is low, the next load goes to the empty threshold again.
- R11: After reset both thresholds equal DEF_OFS (127 by default), the buffer is empty, `rd_data` is 0, `half_full` and `almost_full` are 0, and `almost_empty` is 1.
- R12: With `oe` low, `rd_data` is 0 and `rd_drv` is all zeros. With `oe` high, `rd_drv` is all ones and `rd_data` shows the output word.
- R13: The timing mode is fixed by the mode input during reset. Changes to it after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, both domains |
| fwft_sel | input | 1 | Timing mode sampled during reset (1 = fall-through) |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write data, or a threshold value while `ld` is high |
| ld | input | 1 | Threshold load control |
| rd_en | input | 1 | Read enable |
| oe | input | 1 | Output enable |
| rd_data | output | DATA_W | Read data, zero when not enabled |
| rd_drv | output | DATA_W | Per-bit drive mask standing in for tri-state |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than half the capacity in use |
| almost_empty | output | 1 | Fill at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
The bench builds the block with ADDR_W = 4 (16 words) and DEF_OFS = 3, and ties both clock ports to one clock. With one clock, the three-edge fall-through latency and the two-edge flag crossings fall on fixed cycles that the bench can predict. The small depth puts full, half-full, and both almost thresholds (default and reloaded) within a few dozen cycles. It also lets the bench exercise the fall-through case where the output stage holds one word beyond the storage depth.

// File: rtl/fifo_util_pkg.sv
package fifo_util_pkg;

  // selector of the threshold register targeted by the next load
  typedef enum logic {SEL_EMPTY_THR = 1'b0, SEL_FULL_THR = 1'b1} thr_sel_e;

  function automatic logic [15:0] bin_to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= INIT;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_util_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEF_OFS = 127,
  localparam int LW = ADDR_W + 1
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              fwft_sel,
  input  logic              wr_en,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic [LW-1:0]     rgray_s,
  output logic              push,
  output logic [ADDR_W-1:0] waddr,
  output logic [LW-1:0]     wgray,
  output logic              wr_flag,
  output logic              half_full,
  output logic              almost_full,
  output logic [ADDR_W-1:0] empty_thr
);
  localparam logic [LW-1:0] DEPTH = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W-1:0] DEF_THR = ADDR_W'(DEF_OFS);

  logic [LW-1:0] wbin, rbin_s, level, free;
  logic          full, fwft_w;
  logic [ADDR_W-1:0] full_thr;
  thr_sel_e      sel;

  // mode captured only while reset is held
  always_ff @(posedge wclk) if (!rst_n) fwft_w <= fwft_sel;

  assign rbin_s = LW'(gray_to_bin(16'(rgray_s)));
  assign level  = wbin - rbin_s;
  assign free   = DEPTH - level;
  assign full   = (level == DEPTH);
  assign push   = wr_en & ~ld & ~full;
  assign waddr  = wbin[ADDR_W-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin + LW'(1);
      wgray <= LW'(bin_to_gray(16'(wbin + LW'(1))));
    end
  end

  // threshold load sequencer
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= SEL_EMPTY_THR;
      empty_thr <= DEF_THR;
      full_thr  <= DEF_THR;
    end else if (!ld) begin
      sel <= SEL_EMPTY_THR;
    end else if (wr_en) begin
      if (sel == SEL_EMPTY_THR) begin
        empty_thr <= ld_val;
        sel       <= SEL_FULL_THR;
      end else begin
        full_thr  <= ld_val;
        sel       <= SEL_EMPTY_THR;
      end
    end
  end

  assign wr_flag     = fwft_w ? ~full : full;
  assign half_full   = level > (DEPTH >> 1);
  assign almost_full = free <= {1'b0, full_thr};

  a_r5_full_write_ignored: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wbin));
  a_r4_level_bounded: assert property (@(posedge wclk) disable iff (!rst_n)
    level <= DEPTH);
  a_r7_full_above_half: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_flag == ~fwft_w |-> half_full);
  a_r10_load_not_stored: assert property (@(posedge wclk) disable iff (!rst_n)
    ld |=> $stable(wbin));
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_util_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18,
  localparam int LW = ADDR_W + 1
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_sel,
  input  logic              rd_en,
  input  logic [LW-1:0]     wgray_s,
  input  logic [ADDR_W-1:0] empty_thr,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] raddr,
  output logic [LW-1:0]     rgray,
  output logic [DATA_W-1:0] dout,
  output logic              rd_flag,
  output logic              almost_empty
);
  logic [LW-1:0] rbin, wbin_s, avail, held;
  logic          fwft_r, mem_empty, fetch, ov;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge rclk) if (!rst_n) fwft_r <= fwft_sel;

  assign wbin_s    = LW'(gray_to_bin(16'(wgray_s)));
  assign avail     = wbin_s - rbin;
  assign mem_empty = (avail == '0);
  assign fetch     = fwft_r ? (~mem_empty & (~ov | rd_en)) : (rd_en & ~mem_empty);
  assign raddr     = rbin[ADDR_W-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      dout_q <= '0;
    end else if (fetch) begin
      rbin   <= rbin + LW'(1);
      rgray  <= LW'(bin_to_gray(16'(rbin + LW'(1))));
      dout_q <= mem_q;
    end
  end

  // output-stage valid bit, used in fall-through timing only
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)      ov <= 1'b0;
    else if (!fwft_r) ov <= 1'b0;
    else if (fetch)  ov <= 1'b1;
    else if (rd_en)  ov <= 1'b0;
  end

  assign held         = avail + (ov ? LW'(1) : LW'(0));
  assign almost_empty = held <= {1'b0, empty_thr};
  assign rd_flag      = fwft_r ? ov : mem_empty;
  assign dout         = dout_q;

  a_r6_empty_read_ignored: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_r && mem_empty && rd_en) |=> $stable(rbin));
  a_r2_std_holds_without_read: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_r && !rd_en) |=> $stable(dout_q));
  a_r3_ready_word_held: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_r && ov && !rd_en) |=> (ov && $stable(dout_q)));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18,
  parameter int DEF_OFS = 127
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld,
  input  logic              rd_en,
  input  logic              oe,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rd_drv,
  output logic              rd_flag,
  output logic              wr_flag,
  output logic              half_full,
  output logic              almost_empty,
  output logic              almost_full
);
  localparam int LW = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              push;
  logic [ADDR_W-1:0] waddr, raddr, empty_thr_w, empty_thr_r;
  logic [LW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] dout, mem_q;

  fifo_wr_ctl #(.ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wr_en(wr_en), .ld(ld),
    .ld_val(wr_data[ADDR_W-1:0]), .rgray_s(rgray_s), .push(push), .waddr(waddr),
    .wgray(wgray), .wr_flag(wr_flag), .half_full(half_full),
    .almost_full(almost_full), .empty_thr(empty_thr_w));

  fifo_sync #(.W(LW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  fifo_sync #(.W(LW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
  // threshold is quasi-static: it is reloaded only while the load control is held
  fifo_sync #(.W(ADDR_W), .INIT(ADDR_W'(DEF_OFS))) u_thr (
    .clk(rclk), .rst_n(rst_n), .d(empty_thr_w), .q(empty_thr_r));

  always_ff @(posedge wclk) if (push) mem[waddr] <= wr_data;
  assign mem_q = mem[raddr];

  fifo_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .rd_en(rd_en),
    .wgray_s(wgray_s), .empty_thr(empty_thr_r), .mem_q(mem_q), .raddr(raddr),
    .rgray(rgray), .dout(dout), .rd_flag(rd_flag), .almost_empty(almost_empty));

  assign rd_drv  = {DATA_W{oe}};
  assign rd_data = oe ? dout : '0;
endmodule

// File: tb/tb_dual_clock_fifo.sv
module tb_dual_clock_fifo;
  localparam int AW = 4;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0, fwft_sel = 1'b0, wr_en = 1'b0, ld = 1'b0, rd_en = 1'b0, oe = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, rd_drv;
  logic rd_flag, wr_flag, half_full, almost_empty, almost_full;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dual_clock_fifo #(.ADDR_W(AW), .DATA_W(DW), .DEF_OFS(3)) dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wr_en(wr_en),
    .wr_data(wr_data), .ld(ld), .rd_en(rd_en), .oe(oe), .rd_data(rd_data),
    .rd_drv(rd_drv), .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_to(input logic m);
    wr_en = 0; rd_en = 0; ld = 0;
    rst_n = 0; fwft_sel = m;
    idle(3);
    rst_n = 1;
    idle(1);
  endtask

  task automatic push1(input logic [DW-1:0] d);
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pop1();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset();
    reset_to(1'b0);
    chk("R11 empty after reset", rd_flag, 1);
    chk("R11 full flag after reset", wr_flag, 0);
    chk("R11 half_full after reset", half_full, 0);
    chk("R11 almost_empty after reset", almost_empty, 1);
    chk("R11 almost_full after reset", almost_full, 0);
    chk("R11 rd_data after reset", rd_data, 0);
    chk("R12 drive mask with oe", rd_drv, 32'h3FFFF);
  endtask

  task automatic t_standard();
    reset_to(1'b0);
    fwft_sel = 1'b1;                // R13: ignored after reset
    push1(18'h155);
    idle(4);
    chk("R2 not empty after write", rd_flag, 0);
    chk("R13 no fall-through after mode change", rd_data, 0);
    pop1();
    chk("R2 word after read", rd_data, 18'h155);
    chk("R2 empty after last read", rd_flag, 1);
    pop1();
    chk("R6 empty read keeps data", rd_data, 18'h155);
    push1(18'h0AA);
    idle(4);
    pop1();
    chk("R6 pointer unchanged by empty read", rd_data, 18'h0AA);
    oe = 0; #1;
    chk("R12 data masked", rd_data, 0);
    chk("R12 drive mask off", rd_drv, 0);
    oe = 1; #1;
    chk("R12 data restored", rd_data, 18'h0AA);
    fwft_sel = 1'b0;
  endtask

  task automatic t_fill();
    reset_to(1'b0);
    for (int i = 0; i < 16; i++) begin
      push1(18'(18'h100 + i));
      chk("R7 half_full vs count", half_full, ((i + 1) > 8) ? 1 : 0);
      chk("R9 almost_full vs count", almost_full, ((i + 1) >= 13) ? 1 : 0);
      chk("R4 full flag vs count", wr_flag, ((i + 1) == 16) ? 1 : 0);
    end
    push1(18'h3FF);
    chk("R5 still full after extra write", wr_flag, 1);
    idle(4);
    chk("R8 not almost empty when full", almost_empty, 0);
    for (int k = 0; k < 16; k++) begin
      pop1();
      chk("R1 order", rd_data, 18'(18'h100 + k));
      chk("R8 almost_empty vs count", almost_empty, ((15 - k) <= 3) ? 1 : 0);
    end
    chk("R5 extra word not stored", rd_flag, 1);
    pop1();
    chk("R5 read after drain keeps last", rd_data, 18'h10F);
    idle(3);
    chk("R4 full clears after drain", wr_flag, 0);
    chk("R7 half_full clears after drain", half_full, 0);
  endtask

  task automatic t_fwft();
    reset_to(1'b1);
    chk("R3 not ready after reset", rd_flag, 0);
    chk("R4 input ready after reset", wr_flag, 1);
    wr_data = 18'h2A1; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk("R3 not ready edge 1", rd_flag, 0);
    @(negedge clk);
    chk("R3 not ready edge 2", rd_flag, 0);
    @(negedge clk);
    chk("R3 not ready edge 3 pending", rd_flag, 0);
    @(negedge clk);
    chk("R3 ready after third edge", rd_flag, 1);
    chk("R3 word fell through", rd_data, 18'h2A1);
    idle(2);
    chk("R3 word held without read", rd_data, 18'h2A1);
    pop1();
    chk("R3 not ready after consume", rd_flag, 0);
    for (int i = 0; i < 17; i++) begin
      push1(18'(18'h200 + i));
      if (i == 15) chk("R4 ready with output stage used", wr_flag, 1);
    end
    chk("R4 not ready when full", wr_flag, 0);
    push1(18'h3EE);
    idle(4);
    for (int i = 0; i < 17; i++) begin
      chk("R3 ready during drain", rd_flag, 1);
      chk("R1 fall-through order", rd_data, 18'(18'h200 + i));
      chk("R8 almost_empty counts output word", almost_empty, ((17 - i) <= 3) ? 1 : 0);
      pop1();
    end
    chk("R5 extra word not stored", rd_flag, 0);
    chk("R8 almost_empty after drain", almost_empty, 1);
  endtask

  task automatic t_load();
    reset_to(1'b0);
    ld = 1; wr_en = 1;
    wr_data = 18'd5;  @(negedge clk);
    wr_data = 18'd10; @(negedge clk);
    wr_data = 18'd1;  @(negedge clk);
    ld = 0; wr_en = 0;
    idle(3);
    chk("R10 load stores no data", rd_flag, 1);
    chk("R10 load leaves half_full", half_full, 0);
    push1(18'h011);
    idle(3);
    chk("R10 wrapped empty threshold 1 at one word", almost_empty, 1);
    push1(18'h012);
    idle(3);
    chk("R10 wrapped empty threshold 1 at two words", almost_empty, 0);
    push1(18'h013); push1(18'h014); push1(18'h015);
    chk("R10 full threshold 10 at five words", almost_full, 0);
    push1(18'h016);
    chk("R10 full threshold 10 at six words", almost_full, 1);
    ld = 1; wr_en = 1; wr_data = 18'd3; @(negedge clk);
    ld = 0; wr_en = 0; @(negedge clk);
    ld = 1; wr_en = 1; wr_data = 18'd8; @(negedge clk);
    ld = 0; wr_en = 0;
    idle(3);
    chk("R10 restart loads empty threshold", almost_empty, 1);
    chk("R10 restart leaves full threshold", almost_full, 1);
    pop1();
    chk("R10 loads did not enter storage", rd_data, 18'h011);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_standard();
    t_fill();
    t_fwft();
    t_load();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule